// File: doc/BRIEF.md
# Paired Single/Double Floating-Point Register File

This block is the register storage for a floating-point unit. It holds thirty-two 32-bit words. Each read or write port chooses how it sees that storage. In single mode one register is one word. In double mode an even index names a 64-bit value that spans two registers: the even register holds the low half and the next odd register holds the high half. A double access carries only the even index, and the odd partner is selected automatically. Register 0 is an ordinary register.

Two read ports and one main write port each have their own precision select. The register file also has four raw 32-bit paths, and none of them converts the data:
- a word arriving from the integer side can be written into a floating-point register;
- any register can be read out to the integer side;
- one floating-point register can be copied into another;
- a memory word can be loaded into a register, or a register can be presented for a store.

The load and store paths check the byte offset of the memory address and refuse a transfer that is not word-aligned. Reads are combinational and forward a write made in the same cycle. The register file accepts one write source per cycle, chosen by a fixed priority.

Top module: `fp_pair_regfile`

## Requirements
- R1: An active-low asynchronous reset clears all 32 registers to zero. Register 0 keeps any pattern written to it, including nonzero patterns.
- R2: A single-mode write (`wr_dbl_i`=0) stores `wr_data_i[31:0]` into register `wr_idx_i` at the rising clock edge. No other register changes.
- R3: A double-mode write with an even index p stores `wr_data_i[31:0]` into register p and `wr_data_i[63:32]` into register p+1. A double-mode read at an even index p returns {reg[p+1], reg[p]}.
- R4: A double-mode access with an odd index is illegal:
  - For the write port, `wr_bad_o` rises in the same cycle and no register changes.
  - For a read port, its bad flag rises and its data output is all zeros.
- R5: A single-mode read returns the 32-bit register value zero-extended to 64 bits.
- R6: A read in the same cycle as a write to the register being read returns the value being written. This forwarding applies to both halves of a double read, to the integer-side read and to the store data.
- R7: An integer-to-float move writes `mtf_word_i` bit for bit into register `mtf_idx_i`. `mff_word_o` shows register `mff_idx_i` bit for bit.
- R8: A register-to-register move copies all 32 bits of register `mov_src_i` into register `mov_dst_i`.
- R9: A load with byte offset `ld_boff_i`=2'b00 writes `ld_word_i` into register `ld_idx_i`. A load with any nonzero offset raises `ld_align_err_o` and changes no register.
- R10: A store presents register `st_idx_i` on `st_data_o`. With offset 2'b00, `st_we_o`=1. With any nonzero offset, `st_we_o`=0 and `st_align_err_o`=1.
- R11: Only one write source is taken per cycle, in the priority order main write, load, integer move, register move. A lower source is dropped whenever a higher one is enabled, even if the higher request is itself rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes land on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 5 | Read port A register index |
| rd_a_dbl_i | input | 1 | Read port A double-mode select |
| rd_a_data_o | output | 64 | Read port A data |
| rd_a_bad_o | output | 1 | Read port A illegal odd double index |
| rd_b_idx_i | input | 5 | Read port B register index |
| rd_b_dbl_i | input | 1 | Read port B double-mode select |
| rd_b_data_o | output | 64 | Read port B data |
| rd_b_bad_o | output | 1 | Read port B illegal odd double index |
| wr_en_i | input | 1 | Main write enable |
| wr_dbl_i | input | 1 | Main write double-mode select |
| wr_idx_i | input | 5 | Main write register index |
| wr_data_i | input | 64 | Main write data (low half only in single mode) |
| wr_bad_o | output | 1 | Main write illegal odd double index |
| ld_en_i | input | 1 | Load write enable |
| ld_idx_i | input | 5 | Load target register |
| ld_boff_i | input | 2 | Byte offset of the load address |
| ld_word_i | input | 32 | Loaded memory word |
| ld_align_err_o | output | 1 | Load address not word-aligned |
| mtf_en_i | input | 1 | Integer-to-float move enable |
| mtf_idx_i | input | 5 | Integer-to-float target register |
| mtf_word_i | input | 32 | Raw word from the integer side |
| mff_idx_i | input | 5 | Register read out to the integer side |
| mff_word_o | output | 32 | Raw word to the integer side |
| mov_en_i | input | 1 | Register-to-register move enable |
| mov_src_i | input | 5 | Move source register |
| mov_dst_i | input | 5 | Move destination register |
| st_en_i | input | 1 | Store request |
| st_idx_i | input | 5 | Store source register |
| st_boff_i | input | 2 | Byte offset of the store address |
| st_data_o | output | 32 | Store data |
| st_we_o | output | 1 | Store accepted, aligned |
| st_align_err_o | output | 1 | Store address not word-aligned |

## Verification
The assertions check the following properties every cycle:
- illegal double writes and misaligned loads never reach the storage;
- a double write always pairs an even word with its odd partner;
- a bad read drives zeros;
- a misaligned store never raises its write strobe;
- each accepted word lands in the addressed register;
- the main write always wins arbitration.

Some behaviour cannot be seen from one cycle's signals, so only the bench scenarios show it:
- the full mapping of 64-bit values onto register pairs across all sixteen pairs;
- forwarding into each half of a double read;
- the raw, unconverted data paths;
- the dropping of lower-priority sources behind a rejected higher one.

The bench shows these by sweeping every register and pair and checking the whole file against a model.

// File: rtl/fp_rf_pkg.sv
`timescale 1ns/1ps
package fp_rf_pkg;
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_WR,
    SRC_LD,
    SRC_MTF,
    SRC_MOV
  } wr_src_e;
endpackage

// File: rtl/fp_rf_wr_arb.sv
`timescale 1ns/1ps
module fp_rf_wr_arb
  import fp_rf_pkg::*;
#(
  parameter int unsigned NREG   = 32,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG),
  localparam int unsigned DW    = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_dbl_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [1:0]        ld_boff_i,
  input  logic [WORD_W-1:0] ld_word_i,
  input  logic              mtf_en_i,
  input  logic [IDX_W-1:0]  mtf_idx_i,
  input  logic [WORD_W-1:0] mtf_word_i,
  input  logic              mov_en_i,
  input  logic [IDX_W-1:0]  mov_dst_i,
  input  logic [WORD_W-1:0] mov_word_i,
  output logic              w0_en_o,
  output logic [IDX_W-1:0]  w0_idx_o,
  output logic [WORD_W-1:0] w0_data_o,
  output logic              w1_en_o,
  output logic [IDX_W-1:0]  w1_idx_o,
  output logic [WORD_W-1:0] w1_data_o,
  output logic              wr_bad_o,
  output logic              ld_align_err_o
);
  wr_src_e src;

  assign wr_bad_o       = wr_en_i & wr_dbl_i & wr_idx_i[0];
  assign ld_align_err_o = ld_en_i & (|ld_boff_i);

  always_comb begin
    if (wr_en_i)       src = SRC_WR;
    else if (ld_en_i)  src = SRC_LD;
    else if (mtf_en_i) src = SRC_MTF;
    else if (mov_en_i) src = SRC_MOV;
    else               src = SRC_NONE;
  end

  // upper write channel only ever carries the odd half of a pair
  assign w1_idx_o  = {wr_idx_i[IDX_W-1:1], 1'b1};
  assign w1_data_o = wr_data_i[DW-1:WORD_W];

  always_comb begin
    w0_en_o   = 1'b0;
    w1_en_o   = 1'b0;
    w0_idx_o  = wr_idx_i;
    w0_data_o = wr_data_i[WORD_W-1:0];
    unique case (src)
      SRC_WR: begin
        w0_en_o = ~wr_bad_o;
        w1_en_o = wr_dbl_i & ~wr_bad_o;
      end
      SRC_LD: begin
        w0_en_o   = ~ld_align_err_o;
        w0_idx_o  = ld_idx_i;
        w0_data_o = ld_word_i;
      end
      SRC_MTF: begin
        w0_en_o   = 1'b1;
        w0_idx_o  = mtf_idx_i;
        w0_data_o = mtf_word_i;
      end
      SRC_MOV: begin
        w0_en_o   = 1'b1;
        w0_idx_o  = mov_dst_i;
        w0_data_o = mov_word_i;
      end
      default: ;
    endcase
  end

  AST_ODD_DBL_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_dbl_i && wr_idx_i[0]) |-> (!w0_en_o && !w1_en_o)); // R4
  AST_MISALIGN_LD_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en_i && !wr_en_i && ld_boff_i != 2'b00) |-> !w0_en_o); // R9
  AST_PAIR_SHAPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w1_en_o |-> (w0_en_o && !w0_idx_o[0] && w1_idx_o == (w0_idx_o | IDX_W'(1)))); // R3
  AST_MAIN_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_dbl_i) |-> (w0_en_o && w0_idx_o == wr_idx_i
                                && w0_data_o == wr_data_i[WORD_W-1:0])); // R11
endmodule

// File: rtl/fp_rf_store.sv
`timescale 1ns/1ps
module fp_rf_store #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          w0_en_i,
  input  logic [IDX_W-1:0]              w0_idx_i,
  input  logic [WORD_W-1:0]             w0_data_i,
  input  logic                          w1_en_i,
  input  logic [IDX_W-1:0]              w1_idx_i,
  input  logic [WORD_W-1:0]             w1_data_i,
  output logic [NREG-1:0][WORD_W-1:0]   regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[g] <= '0;
      end else if (w0_en_i && w0_idx_i == IDX_W'(g)) begin
        regs_o[g] <= w0_data_i;
      end else if (w1_en_i && w1_idx_i == IDX_W'(g)) begin
        regs_o[g] <= w1_data_i;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (regs_o == '0)); // R1
  AST_WORD_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w0_en_i |=> (regs_o[$past(w0_idx_i)] == $past(w0_data_i))); // R2
  AST_HALF_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w1_en_i |=> (regs_o[$past(w1_idx_i)] == $past(w1_data_i))); // R3
endmodule

// File: rtl/fp_rf_fwd.sv
`timescale 1ns/1ps
module fp_rf_fwd #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0][WORD_W-1:0] regs_i,
  input  logic                        w0_en_i,
  input  logic [IDX_W-1:0]            w0_idx_i,
  input  logic [WORD_W-1:0]           w0_data_i,
  input  logic                        w1_en_i,
  input  logic [IDX_W-1:0]            w1_idx_i,
  input  logic [WORD_W-1:0]           w1_data_i,
  input  logic [IDX_W-1:0]            idx_i,
  output logic [WORD_W-1:0]           word_o
);
  always_comb begin
    if (w0_en_i && w0_idx_i == idx_i)      word_o = w0_data_i;
    else if (w1_en_i && w1_idx_i == idx_i) word_o = w1_data_i;
    else                                   word_o = regs_i[idx_i];
  end
endmodule

// File: rtl/fp_pair_regfile.sv
`timescale 1ns/1ps
module fp_pair_regfile #(
  parameter int unsigned NREG   = 32,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG),
  localparam int unsigned DW    = 2 * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  input  logic              rd_a_dbl_i,
  output logic [DW-1:0]     rd_a_data_o,
  output logic              rd_a_bad_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  input  logic              rd_b_dbl_i,
  output logic [DW-1:0]     rd_b_data_o,
  output logic              rd_b_bad_o,
  input  logic              wr_en_i,
  input  logic              wr_dbl_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic              wr_bad_o,
  input  logic              ld_en_i,
  input  logic [IDX_W-1:0]  ld_idx_i,
  input  logic [1:0]        ld_boff_i,
  input  logic [WORD_W-1:0] ld_word_i,
  output logic              ld_align_err_o,
  input  logic              mtf_en_i,
  input  logic [IDX_W-1:0]  mtf_idx_i,
  input  logic [WORD_W-1:0] mtf_word_i,
  input  logic [IDX_W-1:0]  mff_idx_i,
  output logic [WORD_W-1:0] mff_word_o,
  input  logic              mov_en_i,
  input  logic [IDX_W-1:0]  mov_src_i,
  input  logic [IDX_W-1:0]  mov_dst_i,
  input  logic              st_en_i,
  input  logic [IDX_W-1:0]  st_idx_i,
  input  logic [1:0]        st_boff_i,
  output logic [WORD_W-1:0] st_data_o,
  output logic              st_we_o,
  output logic              st_align_err_o
);
  localparam int unsigned NLK = 6;  // A lo/hi, B lo/hi, integer side, store

  logic [NREG-1:0][WORD_W-1:0] regs;
  logic              w0_en, w1_en;
  logic [IDX_W-1:0]  w0_idx, w1_idx;
  logic [WORD_W-1:0] w0_data, w1_data;
  logic [IDX_W-1:0]  lk_idx  [NLK];
  logic [WORD_W-1:0] lk_word [NLK];

  fp_rf_wr_arb #(.NREG(NREG), .WORD_W(WORD_W)) u_arb (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_dbl_i, .wr_idx_i, .wr_data_i,
    .ld_en_i, .ld_idx_i, .ld_boff_i, .ld_word_i,
    .mtf_en_i, .mtf_idx_i, .mtf_word_i,
    .mov_en_i, .mov_dst_i,
    .mov_word_i     (regs[mov_src_i]),
    .w0_en_o        (w0_en),
    .w0_idx_o       (w0_idx),
    .w0_data_o      (w0_data),
    .w1_en_o        (w1_en),
    .w1_idx_o       (w1_idx),
    .w1_data_o      (w1_data),
    .wr_bad_o,
    .ld_align_err_o
  );

  fp_rf_store #(.NREG(NREG), .WORD_W(WORD_W)) u_store (
    .clk_i, .rst_ni,
    .w0_en_i   (w0_en),
    .w0_idx_i  (w0_idx),
    .w0_data_i (w0_data),
    .w1_en_i   (w1_en),
    .w1_idx_i  (w1_idx),
    .w1_data_i (w1_data),
    .regs_o    (regs)
  );

  assign lk_idx[0] = rd_a_idx_i;
  assign lk_idx[1] = {rd_a_idx_i[IDX_W-1:1], 1'b1};
  assign lk_idx[2] = rd_b_idx_i;
  assign lk_idx[3] = {rd_b_idx_i[IDX_W-1:1], 1'b1};
  assign lk_idx[4] = mff_idx_i;
  assign lk_idx[5] = st_idx_i;

  for (genvar g = 0; g < NLK; g++) begin : g_lk
    fp_rf_fwd #(.NREG(NREG), .WORD_W(WORD_W)) u_fwd (
      .regs_i    (regs),
      .w0_en_i   (w0_en),
      .w0_idx_i  (w0_idx),
      .w0_data_i (w0_data),
      .w1_en_i   (w1_en),
      .w1_idx_i  (w1_idx),
      .w1_data_i (w1_data),
      .idx_i     (lk_idx[g]),
      .word_o    (lk_word[g])
    );
  end

  assign rd_a_bad_o  = rd_a_dbl_i & rd_a_idx_i[0];
  assign rd_a_data_o = rd_a_bad_o ? '0 :
                       rd_a_dbl_i ? {lk_word[1], lk_word[0]} : {{WORD_W{1'b0}}, lk_word[0]};
  assign rd_b_bad_o  = rd_b_dbl_i & rd_b_idx_i[0];
  assign rd_b_data_o = rd_b_bad_o ? '0 :
                       rd_b_dbl_i ? {lk_word[3], lk_word[2]} : {{WORD_W{1'b0}}, lk_word[2]};

  assign mff_word_o     = lk_word[4];
  assign st_data_o      = lk_word[5];
  assign st_align_err_o = st_en_i & (|st_boff_i);
  assign st_we_o        = st_en_i & ~(|st_boff_i);

  AST_RD_A_BAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_bad_o |-> (rd_a_data_o == '0)); // R4
  AST_RD_B_BAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_b_bad_o |-> (rd_b_data_o == '0)); // R4
  AST_ST_MISALIGN_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_en_i && st_boff_i != 2'b00) |-> (!st_we_o && st_align_err_o)); // R10
  AST_SINGLE_RD_ZEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_a_dbl_i |-> (rd_a_data_o[DW-1:WORD_W] == '0)); // R5
endmodule

// File: tb/fp_pair_regfile_bench.sv
`timescale 1ns/1ps
module fp_pair_regfile_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx, ld_idx, mtf_idx, mff_idx, mov_src, mov_dst, st_idx;
  logic        rd_a_dbl, rd_b_dbl, wr_en, wr_dbl, ld_en, mtf_en, mov_en, st_en;
  logic [63:0] wr_data;
  logic [1:0]  ld_boff, st_boff;
  logic [31:0] ld_word, mtf_word;
  logic [63:0] rd_a_data, rd_b_data;
  logic        rd_a_bad, rd_b_bad, wr_bad, ld_err, st_we, st_err;
  logic [31:0] mff_word, st_data;

  fp_pair_regfile u_fp_pair_regfile (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_a_idx_i(rd_a_idx), .rd_a_dbl_i(rd_a_dbl), .rd_a_data_o(rd_a_data), .rd_a_bad_o(rd_a_bad),
    .rd_b_idx_i(rd_b_idx), .rd_b_dbl_i(rd_b_dbl), .rd_b_data_o(rd_b_data), .rd_b_bad_o(rd_b_bad),
    .wr_en_i(wr_en), .wr_dbl_i(wr_dbl), .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wr_bad_o(wr_bad),
    .ld_en_i(ld_en), .ld_idx_i(ld_idx), .ld_boff_i(ld_boff), .ld_word_i(ld_word),
    .ld_align_err_o(ld_err),
    .mtf_en_i(mtf_en), .mtf_idx_i(mtf_idx), .mtf_word_i(mtf_word),
    .mff_idx_i(mff_idx), .mff_word_o(mff_word),
    .mov_en_i(mov_en), .mov_src_i(mov_src), .mov_dst_i(mov_dst),
    .st_en_i(st_en), .st_idx_i(st_idx), .st_boff_i(st_boff),
    .st_data_o(st_data), .st_we_o(st_we), .st_align_err_o(st_err)
  );

  int unsigned nvec = 0;
  int unsigned nerr = 0;
  logic [31:0] mdl [32];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_dbl = 0; wr_idx = 0; wr_data = 0;
    ld_en = 0; ld_idx = 0; ld_boff = 0; ld_word = 0;
    mtf_en = 0; mtf_idx = 0; mtf_word = 0;
    mov_en = 0; mov_src = 0; mov_dst = 0;
    st_en = 0; st_idx = 0; st_boff = 0;
    rd_a_idx = 0; rd_a_dbl = 0; rd_b_idx = 0; rd_b_dbl = 0; mff_idx = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] pat(input int i, input logic [31:0] s);
    return (32'h9E3779B9 * (i + 1)) ^ s;
  endfunction

  // whole-file comparison through read A (single), read B (double), integer side
  task automatic check_all(input string tag);
    for (int i = 0; i < 32; i++) begin
      rd_a_idx = 5'(i); rd_a_dbl = 0; mff_idx = 5'(i);
      rd_b_idx = 5'(i & 30); rd_b_dbl = 1;
      #1;
      chk({tag, " R5 single read"}, rd_a_data, {32'h0, mdl[i]});
      chk({tag, " R7 int-side read"}, {32'h0, mff_word}, {32'h0, mdl[i]});
      if ((i % 2) == 0) chk({tag, " R3 pair read"}, rd_b_data, {mdl[i+1], mdl[i]});
    end
    rd_b_dbl = 0;
  endtask

  initial begin
    idle();
    for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;
    check_all("R1 reset");

    // R2: single writes to every register, register 0 included
    for (int i = 0; i < 32; i++) begin
      wr_en = 1; wr_dbl = 0; wr_idx = 5'(i); wr_data = {32'hDEAD0000, pat(i, 32'h0)};
      step(); idle();
      mdl[i] = pat(i, 32'h0);
    end
    check_all("R2 single sweep");
    chk("R1 reg0 holds nonzero", {32'h0, mdl[0]}, {32'h0, pat(0, 32'h0)});

    // R3: double writes to every pair
    for (int p = 0; p < 32; p += 2) begin
      wr_en = 1; wr_dbl = 1; wr_idx = 5'(p);
      wr_data = {pat(p, 32'h55AA55AA), pat(p, 32'h0F0F0F0F)};
      #1 chk("R4 legal dbl flag", {63'h0, wr_bad}, 64'h0);
      step(); idle();
      mdl[p] = pat(p, 32'h0F0F0F0F); mdl[p+1] = pat(p, 32'h55AA55AA);
    end
    check_all("R3 pair sweep");

    // R4: odd double writes and reads are rejected
    for (int p = 1; p < 32; p += 2) begin
      wr_en = 1; wr_dbl = 1; wr_idx = 5'(p); wr_data = 64'hFFFF_FFFF_FFFF_FFFF;
      rd_a_idx = 5'(p); rd_a_dbl = 1; rd_b_idx = 5'(p); rd_b_dbl = 1;
      #1;
      chk("R4 wr_bad", {63'h0, wr_bad}, 64'h1);
      chk("R4 rd_a bad data", {rd_a_bad, rd_a_data[62:0]}, {1'b1, 63'h0});
      chk("R4 rd_b bad data", {rd_b_bad, rd_b_data[62:0]}, {1'b1, 63'h0});
      step(); idle();
    end
    check_all("R4 after odd dbl");

    // R6: same-cycle forwarding
    wr_en = 1; wr_dbl = 0; wr_idx = 5; wr_data = {32'h0, 32'hC0FFEE05};
    rd_a_idx = 5; mff_idx = 5; st_en = 1; st_idx = 5; rd_b_idx = 4; rd_b_dbl = 1;
    #1;
    chk("R6 fwd single", rd_a_data, {32'h0, 32'hC0FFEE05});
    chk("R6 fwd int side", {32'h0, mff_word}, {32'h0, 32'hC0FFEE05});
    chk("R6 fwd store", {32'h0, st_data}, {32'h0, 32'hC0FFEE05});
    chk("R6 fwd hi half", rd_b_data, {32'hC0FFEE05, mdl[4]});
    step(); idle(); mdl[5] = 32'hC0FFEE05;
    wr_en = 1; wr_dbl = 1; wr_idx = 8; wr_data = 64'h1111_2222_3333_4444;
    rd_a_idx = 9; rd_b_idx = 8; rd_b_dbl = 1;
    #1;
    chk("R6 fwd odd of pair", rd_a_data, {32'h0, 32'h11112222});
    chk("R6 fwd full pair", rd_b_data, 64'h1111_2222_3333_4444);
    step(); idle(); mdl[8] = 32'h33334444; mdl[9] = 32'h11112222;

    // R7: raw integer-side transfers, including a NaN-like pattern
    for (int i = 0; i < 32; i += 3) begin
      mtf_en = 1; mtf_idx = 5'(i); mtf_word = 32'h7FC00000 ^ 32'(i);
      step(); idle(); mdl[i] = 32'h7FC00000 ^ 32'(i);
      mff_idx = 5'(i); #1;
      chk("R7 int round trip", {32'h0, mff_word}, {32'h0, mdl[i]});
    end

    // R8: register copies
    for (int i = 0; i < 31; i++) begin
      mov_en = 1; mov_src = 5'(i); mov_dst = 5'(31 - i);
      step(); idle(); mdl[31 - i] = mdl[i];
    end
    check_all("R8 move sweep");

    // R9: loads across all byte offsets
    for (int off = 0; off < 4; off++) begin
      for (int i = 0; i < 32; i += 5) begin
        ld_en = 1; ld_idx = 5'(i); ld_boff = 2'(off); ld_word = pat(i, 32'(off) << 24);
        #1 chk("R9 ld align flag", {63'h0, ld_err}, {63'h0, off != 0});
        step(); idle();
        if (off == 0) mdl[i] = pat(i, 32'(off) << 24);
      end
    end
    check_all("R9 load sweep");

    // R10: stores across all byte offsets
    for (int off = 0; off < 4; off++) begin
      for (int i = 0; i < 32; i += 7) begin
        st_en = 1; st_idx = 5'(i); st_boff = 2'(off);
        #1;
        chk("R10 st data", {32'h0, st_data}, {32'h0, mdl[i]});
        chk("R10 st strobes", {62'h0, st_we, st_err}, {62'h0, off == 0, off != 0});
        idle();
      end
    end

    // R11: arbitration
    wr_en = 1; wr_idx = 20; wr_data = {32'h0, 32'hAAAA0020};
    ld_en = 1; ld_idx = 21; ld_word = 32'hBBBB0021;
    mtf_en = 1; mtf_idx = 22; mtf_word = 32'hCCCC0022;
    mov_en = 1; mov_src = 0; mov_dst = 23;
    step(); idle(); mdl[20] = 32'hAAAA0020;
    check_all("R11 main wins");
    ld_en = 1; ld_idx = 21; ld_word = 32'hBBBB0021;
    mtf_en = 1; mtf_idx = 22; mtf_word = 32'hCCCC0022;
    mov_en = 1; mov_src = 0; mov_dst = 23;
    step(); idle(); mdl[21] = 32'hBBBB0021;
    check_all("R11 load wins");
    mtf_en = 1; mtf_idx = 22; mtf_word = 32'hCCCC0022;
    mov_en = 1; mov_src = 0; mov_dst = 23;
    step(); idle(); mdl[22] = 32'hCCCC0022;
    check_all("R11 int move wins");
    wr_en = 1; wr_dbl = 1; wr_idx = 25; wr_data = 64'h0;
    ld_en = 1; ld_idx = 26; ld_word = 32'hDDDD0026;
    step(); idle();
    check_all("R11 rejected main blocks load");
    ld_en = 1; ld_idx = 26; ld_boff = 2'b10; ld_word = 32'hDDDD0026;
    mtf_en = 1; mtf_idx = 27; mtf_word = 32'hEEEE0027;
    step(); idle();
    check_all("R11 rejected load blocks int move");

    // R1: reset mid-run clears everything
    #0.5 rst_ni = 0;
    #3;
    for (int i = 0; i < 32; i++) mdl[i] = 32'h0;
    check_all("R1 mid-run reset");
    rst_ni = 1;

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule